// File: doc/BRIEF.md
# Interrupt Pin Redirection Servicer

This block sits between a bank of interrupt request lines and a memory-write style interrupt fabric. Each request line feeds one pin, and each pin has a 64-bit redirection entry, supplied from outside as a flat table. For each pin the block keeps a pending bit and a busy-lock bit. Edge-mode pins latch a request until it is delivered. Level-mode pins follow their line. A level pin that has been delivered stays locked until the end-of-interrupt side clears the lock.

Any event that may need a delivery starts a service pass. A pass visits every pin, lowest index first. A pin that is pending, unmasked and not locked is turned into an address/data word pair and placed on a registered valid/ready output. Requests are coalesced in three ways: a locked level pin is skipped, a masked pin is skipped and stays pending, and an edge request that arrives on a masked pin is discarded outright.

Top module: `irq_redirect_servicer`

## Requirements
- R1: Request line 0 drives pin 2, ORed with line 2. Every other line n drives pin n. Pin 0 never becomes pending.
- R2: On a level-mode pin (entry bit 15 = 1), pending follows the line: it sets while the line is high and clears when the line goes low.
- R3: A rising edge on an edge-mode pin (bit 15 = 0) whose entry is masked (bit 16 = 1) is discarded. Pending stays clear, and no message is produced for that edge even after a later pass.
- R4: A rising edge on an unmasked edge-mode pin sets pending and starts a pass. The pin's message is then sent and its pending bit cleared.
- R5: Pins that become deliverable in the same pass are sent in ascending pin order.
- R6: A pending pin whose entry is masked is skipped by a pass and stays pending.
- R7: Delivering a level pin sets its busy lock (busy_lock_o). While the lock is set, no message is sent for that pin. Clearing the lock through lock_clr_i while the line is still high and the pin is unmasked causes one new delivery.
- R8: While a pin's entry is in edge mode, its busy lock reads 0 one cycle later.
- R9: Message format. The address is 0xFEE00000 OR destination (entry [63:48]) at address bits [19:4] OR destination mode (entry bit 11) at address bit 2. The data word holds the vector (entry [7:0]) at [7:0], the delivery mode (entry [10:8]) at [10:8] and the trigger bit (entry bit 15) at bit 15. All other data bits are zero.
- R10: At most one message is sent per clock. While msg_valid_o is high and msg_ready_i is low, the valid bit, address and data hold steady and the scan stalls on the current pin.
- R11: After reset, msg_valid_o, pending_o and busy_lock_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| irq_i | input | NUM_PINS | Interrupt request lines |
| entry_tbl_i | input | NUM_PINS*64 | Redirection entries; pin p occupies bits [64p+63:64p] |
| lock_clr_i | input | NUM_PINS | One-cycle pulses that clear a pin's busy lock (end-of-interrupt side) |
| msg_valid_o | output | 1 | Message word pair valid |
| msg_ready_i | input | 1 | Fabric accepts the message |
| msg_addr_o | output | 32 | Message address word |
| msg_data_o | output | 32 | Message data word |
| pending_o | output | NUM_PINS | Pending bit per pin |
| busy_lock_o | output | NUM_PINS | Busy lock per level pin |

## Verification
The hardest case to reach is coalescing of a locked level pin. A level pin is skipped only when it is pending and unmasked and its lock is already set, and only another pin can start the pass that visits it. The bench holds a level line high until its lock sets, fires an edge pin to force a second pass, and expects exactly one message from the edge pin. It then pulses the lock clear while the line is still high and expects one new delivery. Back-pressure is covered in two ways: ready is held low across a pass, and random ready is mixed into multi-pin bursts.

// File: rtl/irs_pkg.sv
package irs_pkg;
  localparam int ENTRY_W   = 64;
  localparam int VEC_LO    = 0;
  localparam int DLV_LO    = 8;
  localparam int DMODE_BIT = 11;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LO   = 48;
  localparam int MSG_W     = 32;

  typedef enum logic {
    SCAN_IDLE,
    SCAN_WALK
  } scan_state_t;

  typedef struct packed {
    logic [MSG_W-1:0] addr;
    logic [MSG_W-1:0] data;
  } irs_msg_t;
endpackage

// File: rtl/irs_capture.sv
module irs_capture #(
  parameter int NUM_PINS = 24,
  parameter int SRC_LINE = 0,
  parameter int DST_PIN  = 2
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [NUM_PINS-1:0] irq_i,
  output logic [NUM_PINS-1:0] lvl_o,
  output logic [NUM_PINS-1:0] rise_o
);
  logic [NUM_PINS-1:0] sync_q;
  logic [NUM_PINS-1:0] mapped;
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q <= irq_i;
      prev_q <= mapped;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
    if (p == DST_PIN) begin : g_dst
      assign mapped[p] = sync_q[p] | sync_q[SRC_LINE];
    end else if (p == SRC_LINE) begin : g_src
      assign mapped[p] = 1'b0;
    end else begin : g_direct
      assign mapped[p] = sync_q[p];
    end
  end

  assign lvl_o  = mapped;
  assign rise_o = mapped & ~prev_q;
endmodule

// File: rtl/irs_pending.sv
module irs_pending #(
  parameter int NUM_PINS = 24,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] rise_i,
  input  logic [NUM_PINS-1:0] lvl_mode_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] lock_clr_i,
  input  logic                take_valid_i,
  input  logic [IDX_W-1:0]    take_idx_i,
  output logic [NUM_PINS-1:0] pend_o,
  output logic [NUM_PINS-1:0] lock_o,
  output logic                pass_req_o
);
  logic [NUM_PINS-1:0] req;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic pend_r;
    logic lock_r;
    logic take_here;

    assign take_here = take_valid_i && (take_idx_i == IDX_W'(p));

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        pend_r <= 1'b0;
        lock_r <= 1'b0;
      end else begin
        if (lvl_mode_i[p]) begin
          pend_r <= lvl_i[p];
        end else if (rise_i[p] && !mask_i[p]) begin
          pend_r <= 1'b1;
        end else if (take_here) begin
          pend_r <= 1'b0;
        end

        if (!lvl_mode_i[p]) begin
          lock_r <= 1'b0;
        end else if (take_here) begin
          lock_r <= 1'b1;
        end else if (lock_clr_i[p]) begin
          lock_r <= 1'b0;
        end
      end
    end

    always_comb begin
      if (lvl_mode_i[p]) begin
        req[p] = (rise_i[p] && !lock_r) ||
                 (lock_clr_i[p] && lock_r && lvl_i[p] && !mask_i[p]);
      end else begin
        req[p] = rise_i[p] && !mask_i[p];
      end
    end

    assign pend_o[p] = pend_r;
    assign lock_o[p] = lock_r;
  end

  assign pass_req_o = |req;
endmodule

// File: rtl/irs_scanner.sv
module irs_scanner
  import irs_pkg::*;
#(
  parameter int          NUM_PINS = 24,
  parameter logic [31:0] MSG_BASE = 32'hFEE0_0000,
  localparam int IDX_W  = $clog2(NUM_PINS),
  localparam int TBL_W  = NUM_PINS * ENTRY_W
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [TBL_W-1:0]    tbl_i,
  input  logic [NUM_PINS-1:0] pend_i,
  input  logic [NUM_PINS-1:0] lock_i,
  input  logic                pass_req_i,
  input  logic                msg_ready_i,
  output logic                take_valid_o,
  output logic [IDX_W-1:0]    take_idx_o,
  output logic                msg_valid_o,
  output logic [MSG_W-1:0]    msg_addr_o,
  output logic [MSG_W-1:0]    msg_data_o
);
  scan_state_t       st_q;
  logic [IDX_W-1:0]  idx_q;
  logic              req_q;
  logic              mv_q;
  irs_msg_t          msg_q;
  irs_msg_t          msg_nx;

  logic [ENTRY_W-1:0] cur_ent;
  logic               unused_ent;
  logic               cand;
  logic               coalesce;
  logic               deliver;
  logic               out_free;
  logic               stall;
  logic               take;
  logic               last;

  assign cur_ent    = tbl_i[idx_q*ENTRY_W +: ENTRY_W];
  assign unused_ent = ^{cur_ent[DEST_LO-1:MASK_BIT+1], cur_ent[TRIG_BIT-1:DMODE_BIT+1]};

  always_comb begin
    cand     = (st_q == SCAN_WALK) && pend_i[idx_q] && !cur_ent[MASK_BIT];
    coalesce = cur_ent[TRIG_BIT] && lock_i[idx_q];
    deliver  = cand && !coalesce;
    out_free = !mv_q || msg_ready_i;
    stall    = deliver && !out_free;
    take     = deliver && out_free;
    last     = (idx_q == IDX_W'(NUM_PINS - 1));

    msg_nx.addr = MSG_BASE
                | {12'h000, cur_ent[DEST_LO +: 16], 4'h0}
                | {29'h0, cur_ent[DMODE_BIT], 2'b00};
    msg_nx.data = {16'h0000, cur_ent[TRIG_BIT], 4'h0,
                   cur_ent[DLV_LO +: 3], cur_ent[VEC_LO +: 8]};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q  <= SCAN_IDLE;
      idx_q <= '0;
      req_q <= 1'b0;
      mv_q  <= 1'b0;
      msg_q <= '0;
    end else begin
      req_q <= pass_req_i | (req_q & (st_q != SCAN_IDLE));

      case (st_q)
        SCAN_IDLE: begin
          if (req_q) begin
            st_q  <= SCAN_WALK;
            idx_q <= '0;
          end
        end
        SCAN_WALK: begin
          if (!stall) begin
            if (last) begin
              st_q <= SCAN_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: st_q <= SCAN_IDLE;
      endcase

      if (take) begin
        mv_q  <= 1'b1;
        msg_q <= msg_nx;
      end else if (msg_ready_i) begin
        mv_q <= 1'b0;
      end
    end
  end

  assign take_valid_o = take;
  assign take_idx_o   = idx_q;
  assign msg_valid_o  = mv_q;
  assign msg_addr_o   = msg_q.addr;
  assign msg_data_o   = msg_q.data;
endmodule

// File: rtl/irq_redirect_servicer.sv
module irq_redirect_servicer
  import irs_pkg::*;
#(
  parameter int          NUM_PINS = 24,
  parameter int          SRC_LINE = 0,
  parameter int          DST_PIN  = 2,
  parameter logic [31:0] MSG_BASE = 32'hFEE0_0000,
  localparam int IDX_W = $clog2(NUM_PINS),
  localparam int TBL_W = NUM_PINS * ENTRY_W
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [NUM_PINS-1:0] irq_i,
  input  logic [TBL_W-1:0]    entry_tbl_i,
  input  logic [NUM_PINS-1:0] lock_clr_i,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [31:0]         msg_addr_o,
  output logic [31:0]         msg_data_o,
  output logic [NUM_PINS-1:0] pending_o,
  output logic [NUM_PINS-1:0] busy_lock_o
);
  logic [NUM_PINS-1:0] lvl;
  logic [NUM_PINS-1:0] rise;
  logic [NUM_PINS-1:0] lvl_mode;
  logic [NUM_PINS-1:0] pin_mask;
  logic [NUM_PINS-1:0] pend;
  logic [NUM_PINS-1:0] lock;
  logic                pass_req;
  logic                take_valid;
  logic [IDX_W-1:0]    take_idx;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_fields
    assign lvl_mode[p] = entry_tbl_i[p*ENTRY_W + TRIG_BIT];
    assign pin_mask[p] = entry_tbl_i[p*ENTRY_W + MASK_BIT];
  end

  irs_capture #(
    .NUM_PINS (NUM_PINS),
    .SRC_LINE (SRC_LINE),
    .DST_PIN  (DST_PIN)
  ) capture_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .irq_i  (irq_i),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  irs_pending #(
    .NUM_PINS (NUM_PINS)
  ) pending_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .lvl_i        (lvl),
    .rise_i       (rise),
    .lvl_mode_i   (lvl_mode),
    .mask_i       (pin_mask),
    .lock_clr_i   (lock_clr_i),
    .take_valid_i (take_valid),
    .take_idx_i   (take_idx),
    .pend_o       (pend),
    .lock_o       (lock),
    .pass_req_o   (pass_req)
  );

  irs_scanner #(
    .NUM_PINS (NUM_PINS),
    .MSG_BASE (MSG_BASE)
  ) scanner_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .tbl_i        (entry_tbl_i),
    .pend_i       (pend),
    .lock_i       (lock),
    .pass_req_i   (pass_req),
    .msg_ready_i  (msg_ready_i),
    .take_valid_o (take_valid),
    .take_idx_o   (take_idx),
    .msg_valid_o  (msg_valid_o),
    .msg_addr_o   (msg_addr_o),
    .msg_data_o   (msg_data_o)
  );

  assign pending_o   = pend;
  assign busy_lock_o = lock;
endmodule

// File: rtl/irs_checker.sv
module irs_checker #(
  parameter int          NUM_PINS = 24,
  parameter int          SRC_LINE = 0,
  parameter logic [31:0] MSG_BASE = 32'hFEE0_0000,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic                msg_valid_i,
  input logic                msg_ready_i,
  input logic [31:0]         msg_addr_i,
  input logic [31:0]         msg_data_i,
  input logic [NUM_PINS-1:0] pend_i,
  input logic [NUM_PINS-1:0] lock_i,
  input logic [NUM_PINS-1:0] rise_i,
  input logic [NUM_PINS-1:0] lvl_mode_i,
  input logic [NUM_PINS-1:0] mask_i,
  input logic                take_valid_i,
  input logic [IDX_W-1:0]    take_idx_i
);
  logic take_lvl;
  assign take_lvl = lvl_mode_i[take_idx_i];

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (msg_valid_i && !msg_ready_i) |=>
      (msg_valid_i && $stable(msg_addr_i) && $stable(msg_data_i)));

  assert_format_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    msg_valid_i |-> (((msg_addr_i & ~32'h000F_FFF4) == MSG_BASE) &&
                     (msg_data_i[31:16] == 16'h0) && (msg_data_i[14:11] == 4'h0)));

  assert_src_idle_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    !pend_i[SRC_LINE]);

  assert_lock_set_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (take_valid_i && take_lvl) |=> lock_i[$past(take_idx_i)]);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
    assert_edge_unlock_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      !lvl_mode_i[p] |=> (!lock_i[p] || lvl_mode_i[p]));

    assert_masked_drop_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (rise_i[p] && !lvl_mode_i[p] && mask_i[p] && !pend_i[p]) |=> !pend_i[p]);
  end
endmodule

bind irq_redirect_servicer irs_checker #(
  .NUM_PINS (NUM_PINS),
  .SRC_LINE (SRC_LINE),
  .MSG_BASE (MSG_BASE)
) checker_i (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .msg_valid_i  (msg_valid_o),
  .msg_ready_i  (msg_ready_i),
  .msg_addr_i   (msg_addr_o),
  .msg_data_i   (msg_data_o),
  .pend_i       (pend),
  .lock_i       (lock),
  .rise_i       (rise),
  .lvl_mode_i   (lvl_mode),
  .mask_i       (pin_mask),
  .take_valid_i (take_valid),
  .take_idx_i   (take_idx)
);

// File: tb/irq_redirect_servicer_tb_top.sv
`timescale 1ns/1ps
module irq_redirect_servicer_tb_top;
  localparam int NP = 24;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NP-1:0]  irq = '0;
  logic [NP-1:0]  lclr = '0;
  logic           ready = 1'b0;
  logic           mvalid;
  logic [31:0]    maddr;
  logic [31:0]    mdata;
  logic [NP-1:0]  pend;
  logic [NP-1:0]  lock;
  logic [63:0]    ent [NP];
  logic [NP*64-1:0] tbl;
  int             rdy_mode = 2;

  int checks = 0;
  int errors = 0;

  logic [31:0] cap_a [1024];
  logic [31:0] cap_d [1024];
  int          cnt = 0;
  int          exp_pins [32];
  int          exp_n;

  always #10 clk = ~clk;

  always_comb begin
    for (int p = 0; p < NP; p++) tbl[p*64 +: 64] = ent[p];
  end

  irq_redirect_servicer dut_i (
    .clk_i       (clk),
    .rst_i       (rst),
    .irq_i       (irq),
    .entry_tbl_i (tbl),
    .lock_clr_i  (lclr),
    .msg_valid_o (mvalid),
    .msg_ready_i (ready),
    .msg_addr_o  (maddr),
    .msg_data_o  (mdata),
    .pending_o   (pend),
    .busy_lock_o (lock)
  );

  always @(posedge clk) begin
    if (rdy_mode == 2) ready <= 1'b1;
    else if (rdy_mode == 1) ready <= 1'b0;
    else ready <= 1'($urandom_range(0, 1));
  end

  always @(negedge clk) begin
    if (!rst && mvalid && ready) begin
      if (cnt < 1024) begin
        cap_a[cnt] = maddr;
        cap_d[cnt] = mdata;
      end
      cnt = cnt + 1;
    end
  end

  function automatic logic [31:0] f_addr(logic [63:0] e);
    return 32'hFEE0_0000 | {12'h0, e[63:48], 4'h0} | {29'h0, e[11], 2'b00};
  endfunction

  function automatic logic [31:0] f_data(logic [63:0] e);
    return {16'h0, e[15], 4'h0, e[10:8], e[7:0]};
  endfunction

  function automatic logic [63:0] mk(logic [15:0] dest, logic dmode, logic [2:0] dm,
                                     logic [7:0] vec, logic lvl, logic msk);
    return {dest, 31'h0, msk, lvl, 3'b000, dmode, dm, vec};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [NP-1:0] m);
    @(negedge clk); irq = irq | m;
    @(negedge clk); irq = irq & ~m;
  endtask

  task automatic verify(input int base, input string rq);
    chk(cnt - base == exp_n, rq, 32'(cnt - base), 32'(exp_n));
    for (int k = 0; k < exp_n && k < cnt - base; k++) begin
      chk(cap_a[base+k] == f_addr(ent[exp_pins[k]]), rq, cap_a[base+k], f_addr(ent[exp_pins[k]]));
      chk(cap_d[base+k] == f_data(ent[exp_pins[k]]), rq, cap_d[base+k], f_data(ent[exp_pins[k]]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10 act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    logic [31:0] held;
    void'($urandom(32'd4242));
    for (int p = 0; p < NP; p++) ent[p] = mk(16'h0, 1'b0, 3'd0, 8'h20, 1'b0, 1'b1);
    cyc(4);
    // R11: reset state
    chk(mvalid == 1'b0, "R11 valid", 32'(mvalid), 0);
    chk(pend == '0, "R11 pending", 32'(pend), 0);
    chk(lock == '0, "R11 lock", 32'(lock), 0);
    rst = 1'b0;
    cyc(3);

    // R4 R9: unmasked edge pin 5
    ent[5] = mk(16'h1234, 1'b1, 3'd3, 8'h31, 1'b0, 1'b0);
    base = cnt; pulse(24'h1 << 5); cyc(60);
    exp_n = 1; exp_pins[0] = 5; verify(base, "R4 R9 edge delivery");
    chk(cap_a[base] == 32'hFEE1_2344, "R9 addr literal", cap_a[base], 32'hFEE1_2344);
    chk(cap_d[base] == 32'h0000_0331, "R9 data literal", cap_d[base], 32'h331);
    chk(pend[5] == 1'b0, "R4 pending cleared", 32'(pend[5]), 0);

    // R1: line 0 reaches pin 2
    ent[2] = mk(16'h00A5, 1'b0, 3'd1, 8'h52, 1'b0, 1'b0);
    base = cnt; pulse(24'h1); cyc(60);
    exp_n = 1; exp_pins[0] = 2; verify(base, "R1 reroute");
    chk(pend[0] == 1'b0, "R1 pin0 idle", 32'(pend[0]), 0);

    // R3: masked edge discarded, no later delivery
    ent[7] = mk(16'h0007, 1'b0, 3'd0, 8'h77, 1'b0, 1'b1);
    base = cnt; pulse(24'h1 << 7); cyc(40);
    chk(pend[7] == 1'b0, "R3 masked edge pending", 32'(pend[7]), 0);
    ent[7][16] = 1'b0;
    cyc(2); pulse(24'h1 << 5); cyc(60);
    exp_n = 1; exp_pins[0] = 5; verify(base, "R3 no late delivery");

    // R5: ascending order
    ent[4] = mk(16'h0004, 1'b0, 3'd2, 8'h44, 1'b0, 1'b0);
    ent[9] = mk(16'h0009, 1'b1, 3'd5, 8'h99, 1'b0, 1'b0);
    ent[20] = mk(16'h0020, 1'b0, 3'd7, 8'hC0, 1'b0, 1'b0);
    rdy_mode = 0;
    base = cnt; pulse((24'h1 << 20) | (24'h1 << 9) | (24'h1 << 4)); cyc(100);
    exp_n = 3; exp_pins[0] = 4; exp_pins[1] = 9; exp_pins[2] = 20; verify(base, "R5 order");
    rdy_mode = 2;

    // R2 R6: masked level pin stays pending, no message
    ent[11] = mk(16'h0011, 1'b0, 3'd0, 8'hB1, 1'b1, 1'b1);
    base = cnt;
    @(negedge clk); irq[11] = 1'b1; cyc(40);
    chk(pend[11] == 1'b1, "R2 level sets pending", 32'(pend[11]), 1);
    pulse(24'h1 << 5); cyc(60);
    chk(pend[11] == 1'b1, "R6 masked stays pending", 32'(pend[11]), 1);
    exp_n = 1; exp_pins[0] = 5; verify(base, "R6 masked skipped");
    @(negedge clk); irq[11] = 1'b0; cyc(5);
    chk(pend[11] == 1'b0, "R2 level clears pending", 32'(pend[11]), 0);

    // R7: lock, coalesce, clear-and-redeliver
    ent[13] = mk(16'hBEEF, 1'b1, 3'd0, 8'h44, 1'b1, 1'b0);
    base = cnt;
    @(negedge clk); irq[13] = 1'b1; cyc(60);
    exp_n = 1; exp_pins[0] = 13; verify(base, "R7 level delivery");
    chk(lock[13] == 1'b1, "R7 lock set", 32'(lock[13]), 1);
    base = cnt; pulse(24'h1 << 5); cyc(60);
    exp_n = 1; exp_pins[0] = 5; verify(base, "R7 coalesced");
    base = cnt;
    @(negedge clk); lclr[13] = 1'b1; @(negedge clk); lclr[13] = 1'b0; cyc(60);
    exp_n = 1; exp_pins[0] = 13; verify(base, "R7 redelivery");
    chk(lock[13] == 1'b1, "R7 lock set again", 32'(lock[13]), 1);
    @(negedge clk); irq[13] = 1'b0; cyc(5);

    // R8: edge mode drops the lock
    chk(lock[13] == 1'b1, "R8 lock before", 32'(lock[13]), 1);
    ent[13][15] = 1'b0; cyc(3);
    chk(lock[13] == 1'b0, "R8 lock cleared", 32'(lock[13]), 0);
    chk(pend[13] == 1'b0, "R8 pending", 32'(pend[13]), 0);

    // R10: stall under back-pressure
    ent[3] = mk(16'h0303, 1'b0, 3'd4, 8'h3C, 1'b0, 1'b0);
    rdy_mode = 1; cyc(3);
    base = cnt; pulse(24'h1 << 3); cyc(40);
    chk(mvalid == 1'b1, "R10 valid held", 32'(mvalid), 1);
    chk(maddr == f_addr(ent[3]), "R10 addr", maddr, f_addr(ent[3]));
    held = mdata; cyc(7);
    chk(mvalid == 1'b1 && mdata == held, "R10 stable", mdata, held);
    rdy_mode = 2; cyc(10);
    exp_n = 1; exp_pins[0] = 3; verify(base, "R10 release");

    // R4 R5 R9: random bursts on edge pins
    for (int p = 0; p < NP; p++)
      ent[p] = mk(16'($urandom), 1'($urandom), 3'($urandom), 8'($urandom), 1'b0, 1'b0);
    rdy_mode = 0;
    for (int r = 0; r < 20; r++) begin
      logic [NP-1:0] b;
      b = NP'($urandom);
      exp_n = 0;
      for (int p = 0; p < NP; p++) begin
        bit hit;
        hit = (p == 2) ? (b[2] | b[0]) : ((p == 0) ? 1'b0 : b[p]);
        if (hit) begin exp_pins[exp_n] = p; exp_n++; end
      end
      base = cnt; pulse(b); cyc(150);
      verify(base, "R5 random burst");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule